// File: doc/BRIEF.md
# Windowed Register File with Spill and Fill

This block holds the integer registers of a processor core as a ring of register windows plus a small bank of globals. A 5-bit logical register number is turned into a physical slot using the current window pointer. Logical 0–7 always reach the globals. Logical 8–15 are the window's incoming arguments, 16–23 are its private locals and 24–31 are its outgoing arguments. The outgoing group of a window occupies the same storage as the incoming group of the window one step further round the ring. A caller therefore hands arguments to a callee simply by writing them before the call; no data is copied.

A call request advances the pointer by one and a return request moves it back by one. At most NWIN-1 windows can be held at once, because the newest window's outgoing group would otherwise land on the oldest window's incoming group. A call made when the ring is full raises the overflow trap and streams the oldest window (incoming group first, then locals) to an external memory that behaves as a stack. Only then does the call complete. A return onto a window that was streamed out raises the underflow trap, reads that window back from memory, and then completes. The memory port is valid/ready. The block holds `mem_valid` together with stable `mem_write`, `mem_addr` and `mem_wdata` until the memory raises `mem_ready`, and the memory may hold `mem_ready` low for any number of cycles. One word moves in each cycle where both are high. On a read (fill) the memory presents `mem_rdata` in the same cycle it raises `mem_ready`.

Top module: `winreg_file`

## Requirements
- R1: Logical registers 0–7 address one global bank that reads and writes identically from every window.
- R2: Logical register 24+i of window w and logical register 8+i of window w+1 (modulo NWIN) are the same storage cell, for i in 0–7.
- R3: Outside a trap, a call request moves `win_ptr` to `win_ptr`+1 modulo NWIN, and a return moves it to `win_ptr`-1. Logical 16–23 are private to each window.
- R4: A read whose logical address equals the address being written in the same cycle returns the new write data in that cycle.
- R5: A call made while NWIN-1 windows are held raises `trap_ovf` until the spill ends. The spill writes the 16 words of the oldest window to addresses {depth, k}, where depth counts the windows already in memory. Word k<8 is incoming register k and word k≥8 is local register k-8. Once the last word is accepted, `win_ptr` advances by one.
- R6: A return made when only the current window is held and at least one window is in memory raises `trap_unf`. The fill reads addresses {depth-1, k} into the window just behind the oldest held one, using the same word order as R5. `win_ptr` then steps back by one.
- R7: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_write`, `mem_addr` and `mem_wdata` keep their values. `mem_write` is 1 during a spill and 0 during a fill.
- R8: Call and return requests made while a trap is raised are dropped, and `win_ptr` does not move during a trap. A call and a return made in the same cycle act as a call.
- R9: A return made when only the current window is held and nothing is in memory is ignored: no trap, and the pointer stays.
- R10: After reset `win_ptr` is 0, both traps and `mem_valid` are low, and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_addr0 | input | 5 | Logical register number, read port 0 |
| rd_addr1 | input | 5 | Logical register number, read port 1 |
| rd_data0 | output | 32 | Read data, port 0 (combinational) |
| rd_data1 | output | 32 | Read data, port 1 (combinational) |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Logical register number to write |
| wr_data | input | 32 | Write data |
| call_req | input | 1 | Procedure call strobe |
| ret_req | input | 1 | Procedure return strobe |
| win_ptr | output | 3 | Current window pointer |
| trap_ovf | output | 1 | Window overflow trap, high during a spill |
| trap_unf | output | 1 | Window underflow trap, high during a fill |
| mem_valid | output | 1 | Memory transfer request |
| mem_ready | input | 1 | Memory accepts or returns the word |
| mem_write | output | 1 | 1 = spill write, 0 = fill read |
| mem_addr | output | 12 | {window depth, word index} |
| mem_wdata | output | 32 | Spilled word |
| mem_rdata | input | 32 | Filled word, valid with mem_ready |

## Verification
The bench drives calls up to the ring's capacity and one call beyond it. It checks that exactly 16 words reach memory at the expected stack slots and in incoming-then-local order. A design that miscounted the held windows would trap one call early or late, and a swapped word order would return the wrong data after a fill. A word in the memory model is altered before the fill, so a design that left the old contents in place instead of reading memory gives the old value. The bench also applies back-pressure during a spill while a second call is pulsed, which catches a port that advances without handshake or a trap that accepts new requests. It also covers a return at the outermost level, a call and a return made together, and a read of the register written in the same cycle.

// File: rtl/winreg_pkg.sv
package winreg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SPILL = 2'd1,
    ST_FILL  = 2'd2
  } wst_e;
endpackage

// File: rtl/winreg_store.sv
module winreg_store #(
  parameter int NWIN = 8,
  parameter int NREG = 8,
  parameter int DW   = 32,
  parameter int NRP  = 2,
  localparam int WW   = $clog2(NWIN),
  localparam int RW   = $clog2(NREG),
  localparam int LAW  = RW + 2,
  localparam int KW   = RW + 1,
  localparam int PW   = WW + KW,
  localparam int NPHY = NWIN * 2 * NREG
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [WW-1:0]            cur_win,
  input  logic                     we,
  input  logic [LAW-1:0]           wa,
  input  logic [DW-1:0]            wd,
  input  logic [NRP-1:0][LAW-1:0]  ra,
  output logic [NRP-1:0][DW-1:0]   rd,
  input  logic [WW-1:0]            spill_win,
  input  logic [KW-1:0]            word_k,
  output logic [DW-1:0]            spill_data,
  input  logic                     fill_we,
  input  logic [WW-1:0]            fill_win,
  input  logic [DW-1:0]            fill_data
);
  logic [DW-1:0] gbank [NREG];
  logic [DW-1:0] wbank [NPHY];

  // Physical slot layout {window, half, index}: half 0 = incoming group, half 1 = locals.
  // The outgoing group of window w is the incoming group of window w+1.
  function automatic logic [PW-1:0] widx(input logic [LAW-1:0] a, input logic [WW-1:0] w);
    logic [WW-1:0] wn;
    logic [RW-1:0] i;
    wn = w + WW'(1);
    i  = a[RW-1:0];
    case (a[LAW-1 -: 2])
      2'd1:    widx = {w, 1'b0, i};
      2'd2:    widx = {w, 1'b1, i};
      default: widx = {wn, 1'b0, i};
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < NREG; j++) gbank[j] <= '0;
      for (int j = 0; j < NPHY; j++) wbank[j] <= '0;
    end else begin
      if (we) begin
        if (wa[LAW-1 -: 2] == 2'd0) gbank[wa[RW-1:0]] <= wd;
        else                        wbank[widx(wa, cur_win)] <= wd;
      end
      if (fill_we) wbank[{fill_win, word_k}] <= fill_data;
    end
  end

  for (genvar p = 0; p < NRP; p++) begin : g_rport
    always_comb begin
      if (ra[p][LAW-1 -: 2] == 2'd0) rd[p] = gbank[ra[p][RW-1:0]];
      else                           rd[p] = wbank[widx(ra[p], cur_win)];
    end
  end

  assign spill_data = wbank[{spill_win, word_k}];
endmodule

// File: rtl/winreg_ctl.sv
module winreg_ctl
  import winreg_pkg::*;
#(
  parameter int NWIN    = 8,
  parameter int NREG    = 8,
  parameter int DEPTH_W = 8,
  localparam int WW  = $clog2(NWIN),
  localparam int KW  = $clog2(NREG) + 1,
  localparam int MAW = DEPTH_W + KW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           call_req,
  input  logic           ret_req,
  input  logic           mem_ready,
  output wst_e           st,
  output logic [WW-1:0]  cwp,
  output logic [WW-1:0]  spill_win,
  output logic [WW-1:0]  fill_win,
  output logic [KW-1:0]  word_k,
  output logic           fill_we,
  output logic           mem_valid,
  output logic           mem_write,
  output logic [MAW-1:0] mem_addr
);
  logic [WW-1:0]      swp;
  logic [WW-1:0]      held;
  logic [DEPTH_W-1:0] depth;
  logic               full, alone, last;

  assign full  = (held == WW'(NWIN - 1));
  assign alone = (held == WW'(1));
  assign last  = (word_k == KW'(2 * NREG - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      cwp    <= '0;
      swp    <= '0;
      held   <= WW'(1);
      depth  <= '0;
      word_k <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          word_k <= '0;
          if (call_req) begin
            if (full) st <= ST_SPILL;
            else begin
              cwp  <= cwp + WW'(1);
              held <= held + WW'(1);
            end
          end else if (ret_req) begin
            if (!alone) begin
              cwp  <= cwp - WW'(1);
              held <= held - WW'(1);
            end else if (depth != '0) st <= ST_FILL;
          end
        end
        ST_SPILL: if (mem_ready) begin
          word_k <= word_k + KW'(1);
          if (last) begin
            swp   <= swp + WW'(1);
            depth <= depth + DEPTH_W'(1);
            cwp   <= cwp + WW'(1);
            st    <= ST_IDLE;
          end
        end
        ST_FILL: if (mem_ready) begin
          word_k <= word_k + KW'(1);
          if (last) begin
            swp   <= swp - WW'(1);
            depth <= depth - DEPTH_W'(1);
            cwp   <= cwp - WW'(1);
            st    <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign spill_win = swp;
  assign fill_win  = swp - WW'(1);
  assign mem_valid = (st != ST_IDLE);
  assign mem_write = (st == ST_SPILL);
  assign fill_we   = (st == ST_FILL) && mem_ready;
  assign mem_addr  = (st == ST_FILL) ? {depth - DEPTH_W'(1), word_k} : {depth, word_k};
endmodule

// File: rtl/winreg_file.sv
module winreg_file
  import winreg_pkg::*;
#(
  parameter int NWIN    = 8,
  parameter int NREG    = 8,
  parameter int DW      = 32,
  parameter int DEPTH_W = 8,
  localparam int WW  = $clog2(NWIN),
  localparam int LAW = $clog2(NREG) + 2,
  localparam int KW  = $clog2(NREG) + 1,
  localparam int MAW = DEPTH_W + KW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [LAW-1:0] rd_addr0,
  input  logic [LAW-1:0] rd_addr1,
  output logic [DW-1:0]  rd_data0,
  output logic [DW-1:0]  rd_data1,
  input  logic           wr_en,
  input  logic [LAW-1:0] wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic           call_req,
  input  logic           ret_req,
  output logic [WW-1:0]  win_ptr,
  output logic           trap_ovf,
  output logic           trap_unf,
  output logic           mem_valid,
  input  logic           mem_ready,
  output logic           mem_write,
  output logic [MAW-1:0] mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata
);
  wst_e                 st;
  logic [WW-1:0]        cwp, spill_win, fill_win;
  logic [KW-1:0]        word_k;
  logic                 fill_we;
  logic [1:0][LAW-1:0]  ra;
  logic [1:0][DW-1:0]   q;

  winreg_ctl #(.NWIN(NWIN), .NREG(NREG), .DEPTH_W(DEPTH_W)) u_ctl (
    .clk(clk), .rst(rst), .call_req(call_req), .ret_req(ret_req),
    .mem_ready(mem_ready), .st(st), .cwp(cwp), .spill_win(spill_win),
    .fill_win(fill_win), .word_k(word_k), .fill_we(fill_we),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr)
  );

  assign ra[0] = rd_addr0;
  assign ra[1] = rd_addr1;

  winreg_store #(.NWIN(NWIN), .NREG(NREG), .DW(DW), .NRP(2)) u_store (
    .clk(clk), .rst(rst), .cur_win(cwp), .we(wr_en), .wa(wr_addr), .wd(wr_data),
    .ra(ra), .rd(q), .spill_win(spill_win), .word_k(word_k),
    .spill_data(mem_wdata), .fill_we(fill_we), .fill_win(fill_win),
    .fill_data(mem_rdata)
  );

  // Same-cycle write forwarding
  assign rd_data0 = (wr_en && wr_addr == rd_addr0) ? wr_data : q[0];
  assign rd_data1 = (wr_en && wr_addr == rd_addr1) ? wr_data : q[1];

  assign win_ptr  = cwp;
  assign trap_ovf = (st == ST_SPILL);
  assign trap_unf = (st == ST_FILL);
endmodule

// File: rtl/winreg_chk.sv
module winreg_chk #(
  parameter int WW  = 3,
  parameter int MAW = 12,
  parameter int DW  = 32
) (
  input logic           clk,
  input logic           rst,
  input logic           call_req,
  input logic           ret_req,
  input logic [WW-1:0]  win_ptr,
  input logic           trap_ovf,
  input logic           trap_unf,
  input logic           mem_valid,
  input logic           mem_ready,
  input logic           mem_write,
  input logic [MAW-1:0] mem_addr,
  input logic [DW-1:0]  mem_wdata
);
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_write) &&
                                   $stable(mem_addr) && $stable(mem_wdata)));

  a_r5_one_trap: assert property (@(posedge clk) disable iff (rst)
    !(trap_ovf && trap_unf));

  a_r3_call_step: assert property (@(posedge clk) disable iff (rst)
    (!trap_ovf && !trap_unf && call_req) |=>
      (trap_ovf || win_ptr == $past(win_ptr) + WW'(1)));

  a_r8_frozen: assert property (@(posedge clk) disable iff (rst)
    (trap_ovf || trap_unf) |-> $stable(win_ptr));

  a_r5_spill_dir: assert property (@(posedge clk) disable iff (rst)
    (trap_ovf && mem_valid) |-> mem_write);

  a_r6_fill_dir: assert property (@(posedge clk) disable iff (rst)
    (trap_unf && mem_valid) |-> !mem_write);

  a_r10_quiet: assert property (@(posedge clk) disable iff (rst)
    (!trap_ovf && !trap_unf) |-> !mem_valid);
endmodule

bind winreg_file winreg_chk #(.WW(WW), .MAW(MAW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .call_req(call_req), .ret_req(ret_req),
  .win_ptr(win_ptr), .trap_ovf(trap_ovf), .trap_unf(trap_unf),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/tb_winreg_file.sv
module tb_winreg_file;
  logic        clk = 0;
  logic        rst = 1;
  logic [4:0]  rd_addr0 = 0, rd_addr1 = 0, wr_addr = 0;
  logic [31:0] rd_data0, rd_data1, wr_data = 0;
  logic        wr_en = 0, call_req = 0, ret_req = 0;
  logic [2:0]  win_ptr;
  logic        trap_ovf, trap_unf, mem_valid, mem_write;
  logic        mem_ready = 1;
  logic [11:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  logic [31:0] tbmem [4096];
  int          nchk = 0, nbad = 0, nwr = 0;
  bit          bp = 0, done = 0, saw;

  always #2.5 clk = ~clk;

  winreg_file dut (
    .clk(clk), .rst(rst), .rd_addr0(rd_addr0), .rd_addr1(rd_addr1),
    .rd_data0(rd_data0), .rd_data1(rd_data1), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .call_req(call_req), .ret_req(ret_req), .win_ptr(win_ptr),
    .trap_ovf(trap_ovf), .trap_unf(trap_unf), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  assign mem_rdata = tbmem[mem_addr];

  always @(posedge clk)
    if (mem_valid && mem_ready && mem_write) begin
      tbmem[mem_addr] <= mem_wdata;
      nwr++;
    end

  always @(negedge clk) mem_ready <= bp ? ~mem_ready : 1'b1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input string tag, input logic [4:0] a, input logic [31:0] exp);
    @(negedge clk); rd_addr0 = a; rd_addr1 = a; #0.5;
    chk(tag, rd_data0, exp);
    chk(tag, rd_data1, exp);
  endtask

  task automatic do_call(input bit extra, output bit trapped);
    @(negedge clk); call_req = 1;
    @(negedge clk); call_req = 0;
    trapped = trap_ovf | trap_unf;
    if (trapped && extra) begin
      call_req = 1; @(negedge clk); call_req = 0;
    end
    while (trap_ovf || trap_unf) @(negedge clk);
  endtask

  task automatic do_ret(output bit trapped);
    @(negedge clk); ret_req = 1;
    @(negedge clk); ret_req = 0;
    trapped = trap_ovf | trap_unf;
    while (trap_ovf || trap_unf) @(negedge clk);
  endtask

  // {op[1:0], reg[4:0], data[31:0], expected[31:0]}; op 0=write 1=read 2=call 3=return
  localparam logic [70:0] VEC [12] = '{
    {2'd0, 5'd3,  32'h1111_0003, 32'h0},
    {2'd0, 5'd26, 32'h0000_0A26, 32'h0},
    {2'd0, 5'd17, 32'h0000_0C17, 32'h0},
    {2'd2, 5'd0,  32'h0,         32'h0},
    {2'd1, 5'd10, 32'h0,         32'h0000_0A26},
    {2'd1, 5'd3,  32'h0,         32'h1111_0003},
    {2'd1, 5'd17, 32'h0,         32'h0},
    {2'd0, 5'd10, 32'h0000_0B10, 32'h0},
    {2'd3, 5'd0,  32'h0,         32'h0},
    {2'd1, 5'd26, 32'h0,         32'h0000_0B10},
    {2'd1, 5'd17, 32'h0,         32'h0000_0C17},
    {2'd1, 5'd3,  32'h0,         32'h1111_0003}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nbad++; nchk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) tbmem[i] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    chk("R10 ptr", {29'b0, win_ptr}, 0);
    chk("R10 traps", {30'b0, trap_ovf, trap_unf}, 0);
    chk("R10 valid", {31'b0, mem_valid}, 0);
    rd("R10 reg zero", 5'd20, 0);

    // Table walk: R1 globals, R2 overlap, R3 private locals
    for (int v = 0; v < 12; v++) begin
      case (VEC[v][70:69])
        2'd0: wr(VEC[v][68:64], VEC[v][63:32]);
        2'd1: rd("R1/R2/R3 vector", VEC[v][68:64], VEC[v][31:0]);
        2'd2: begin do_call(0, saw); chk("R3 call no trap", {31'b0, saw}, 0); end
        default: begin do_ret(saw); chk("R3 ret no trap", {31'b0, saw}, 0); end
      endcase
    end
    chk("R3 ptr back", {29'b0, win_ptr}, 0);

    // R4 forwarding
    @(negedge clk); wr_en = 1; wr_addr = 5'd20; wr_data = 32'hFEED_0020; rd_addr0 = 5'd20;
    #0.5 chk("R4 bypass", rd_data0, 32'hFEED_0020);
    @(negedge clk); wr_en = 0;

    // R8 call beats return
    @(negedge clk); call_req = 1; ret_req = 1;
    @(negedge clk); call_req = 0; ret_req = 0;
    chk("R8 call wins", {29'b0, win_ptr}, 1);
    do_ret(saw);

    // Fill windows 0..6, then overflow
    for (int w = 0; w < 7; w++) begin
      wr(5'd16, 32'h100 + w);
      wr(5'd8,  32'h200 + w);
      if (w < 6) begin
        do_call(0, saw);
        chk("R3 call no trap", {31'b0, saw}, 0);
      end
    end
    chk("R3 ptr at 6", {29'b0, win_ptr}, 6);
    do_call(0, saw);
    chk("R5 ovf trap", {31'b0, saw}, 1);
    chk("R5 ptr after spill", {29'b0, win_ptr}, 7);
    chk("R5 spill count", nwr, 16);
    chk("R5 word0 incoming", tbmem[0], 32'h200);
    chk("R5 word8 local", tbmem[8], 32'h100);
    wr(5'd16, 32'h107);
    wr(5'd8,  32'h207);

    // Second overflow under back-pressure with a dropped call (R7, R8)
    bp = 1;
    do_call(1, saw);
    chk("R5 ovf trap 2", {31'b0, saw}, 1);
    chk("R8 extra call dropped", {29'b0, win_ptr}, 0);
    chk("R7 spill count", nwr, 32);
    chk("R5 depth1 word0", tbmem[16], 32'h201);
    chk("R5 depth1 word8", tbmem[24], 32'h101);
    wr(5'd16, 32'h1A0);
    @(negedge clk); tbmem[24] = 32'hF101;

    for (int r = 0; r < 6; r++) begin
      do_ret(saw);
      chk("R3 ret no trap", {31'b0, saw}, 0);
    end
    chk("R3 ptr at 2", {29'b0, win_ptr}, 2);
    rd("R3 resident local", 5'd16, 32'h102);

    do_ret(saw);
    chk("R6 unf trap", {31'b0, saw}, 1);
    chk("R6 ptr after fill", {29'b0, win_ptr}, 1);
    rd("R6 local from memory", 5'd16, 32'hF101);
    rd("R6 incoming from memory", 5'd8, 32'h201);

    do_ret(saw);
    chk("R6 unf trap 2", {31'b0, saw}, 1);
    chk("R6 ptr at 0", {29'b0, win_ptr}, 0);
    rd("R6 local refilled", 5'd16, 32'h100);
    rd("R6 incoming refilled", 5'd8, 32'h200);
    rd("R1 global kept", 5'd3, 32'h1111_0003);

    // R9 outermost return ignored
    do_ret(saw);
    chk("R9 no trap", {31'b0, saw}, 0);
    chk("R9 ptr stays", {29'b0, win_ptr}, 0);
    chk("R9 spill count", nwr, 32);

    done = 1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule